// File: doc/BRIEF.md
# Transmit Completion Status Queue

The block keeps a first-in, first-out record of finished transmit frames. Each time the transmit MAC reports a completion, the block stores one entry that holds the frame identifier and a set of error and interrupt flags. The host sees the oldest entry through a 16-bit status register. The low byte holds the flags and the high byte holds the frame identifier. To discard the entry and move on to the next one, the host writes to the register with both byte lanes enabled. That full write also retires the entry's part in the transmit-complete interrupt.

The block also gates the transmit MAC through a transmit-enabled output. The MAC is halted when the queue fills, or when a frame ends with excessive collisions, a reclaim error or an underrun. While the MAC is halted, no new completions are accepted, and the entries already queued are kept. A restart request brings the MAC back after collision or reclaim errors, and after the queue has drained below full. After an underrun the MAC stays halted until a controller reset, which also empties the queue.

Top module: `tx_cmpl_statq`

## Requirements
- R1: The queue stores up to 31 entries and presents them to the host oldest first. Each entry carries the frame identifier and the five flags of its completion event.
- R2: While the queue holds an entry, the status register reads as follows. Bits 15:8 hold the frame identifier and bit 7 (done) is 1. Bit 6 is the interrupt-requested flag, bit 4 is underrun, bit 3 is excessive collisions, bit 2 is statistics overflow and bit 1 is reclaim error. Bits 5 and 0 read as 0.
- R3: When the queue is empty, the status register reads 0x0000. A write to an empty queue changes nothing.
- R4: A host write with both byte enables set (`host_be` = 2'b11) pops the head entry. A write with only one byte enable set leaves the same entry visible and leaves the interrupt unchanged.
- R5: `tx_int` is 1 exactly while at least one queued entry has its interrupt-requested flag set. It falls after the last such entry is popped.
- R6: A completion event that arrives in the same cycle as a pop is stored after the pop, so no entry is lost.
- R7: The completion that fills the queue to 31 entries drops `tx_enabled`. A restart request is ignored while the queue is full. The same request takes effect once the queue holds fewer than 31 entries.
- R8: A completion flagged with excessive collisions or a reclaim error is stored and then drops `tx_enabled`. A restart request (`tx_restart`) raises `tx_enabled` again one cycle later.
- R9: A completion flagged with underrun is stored and then drops `tx_enabled`. Restart requests are ignored after that. Only `ctl_reset` recovers: it empties the queue, clears the interrupt and raises `tx_enabled`.
- R10: While `tx_enabled` is 0, completion events are rejected and the queued entries stay unchanged.
- R11: A completion flagged only with statistics overflow is stored with that flag and does not halt the MAC.
- R12: After reset the queue is empty, `tx_int` is 0 and `tx_enabled` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Completion event from the transmit MAC |
| ev_id | input | 8 | Frame identifier of the completed frame |
| ev_intreq | input | 1 | Frame asked for a completion interrupt |
| ev_underrun | input | 1 | Frame ended with a transmit underrun |
| ev_xcoll | input | 1 | Frame ended with excessive collisions |
| ev_stsovf | input | 1 | Statistics counter overflowed |
| ev_reclaim | input | 1 | Frame ended with a reclaim error |
| host_wr | input | 1 | Host write strobe to the status register |
| host_be | input | 2 | Byte enables of the host write |
| host_rdata | output | 16 | Status register read value (head entry) |
| tx_restart | input | 1 | Host sets the transmit-enable control bit |
| ctl_reset | input | 1 | Synchronous controller reset |
| tx_enabled | output | 1 | Transmit MAC is allowed to run |
| tx_int | output | 1 | Transmit-complete interrupt |

## Verification
A wrong read or write pointer shows up at the first read after the fault, as a frame identifier or flag set out of order on `host_rdata`. An occupancy count that drifts shows up within one queue depth of traffic in two ways. Either a stall comes at the wrong fill level, or the register reads empty while entries remain, or the reverse. A miscounted interrupt tally leaves `tx_int` high or low in the cycle after the pop that should have changed it. The bench compares all three outputs against a bench-side queue model after every cycle, so any of these faults is reported in the cycle it first appears.

// File: rtl/tx_cmpl_statq.sv
module tx_cmpl_statq #(
  parameter int DEPTH = 31,
  parameter int ID_W  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ev_valid,
  input  logic [ID_W-1:0] ev_id,
  input  logic            ev_intreq,
  input  logic            ev_underrun,
  input  logic            ev_xcoll,
  input  logic            ev_stsovf,
  input  logic            ev_reclaim,
  input  logic            host_wr,
  input  logic [1:0]      host_be,
  output logic [15:0]     host_rdata,
  input  logic            tx_restart,
  input  logic            ctl_reset,
  output logic            tx_enabled,
  output logic            tx_int
);
  localparam int ENT_W = ID_W + 5;
  localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PW-1:0]    wp, rp;
  logic [CW-1:0]    cnt, icnt;
  logic             ur_lock;

  logic [ENT_W-1:0] head;
  logic             empty, pop, push, stall_ev, can_restart;
  logic [CW-1:0]    cnt_nx;

  assign head     = mem[rp];
  assign empty    = (cnt == '0);
  assign pop      = host_wr && (host_be == 2'b11) && !empty;
  assign push     = ev_valid && tx_enabled;
  assign stall_ev = push && (ev_underrun || ev_xcoll || ev_reclaim);
  assign cnt_nx   = cnt - CW'(pop) + CW'(push);
  assign can_restart = tx_restart && !ur_lock && (cnt < FULL);

  assign host_rdata = empty ? 16'h0000 :
    {head[ENT_W-1 -: ID_W], 1'b1, head[4], 1'b0, head[3:0], 1'b0};
  assign tx_int = (icnt != '0);

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= {ev_id, ev_intreq, ev_underrun, ev_xcoll, ev_stsovf, ev_reclaim};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      icnt <= '0;
      tx_enabled <= 1'b1;
      ur_lock <= 1'b0;
    end else if (ctl_reset) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
      icnt <= '0;
      tx_enabled <= 1'b1;
      ur_lock <= 1'b0;
    end else begin
      if (push) wp <= inc(wp);
      if (pop)  rp <= inc(rp);
      cnt  <= cnt_nx;
      icnt <= icnt - CW'(pop && head[4]) + CW'(push && ev_intreq);
      if (push && ev_underrun) ur_lock <= 1'b1;
      if (stall_ev || (push && cnt_nx == FULL)) tx_enabled <= 1'b0;
      else if (can_restart) tx_enabled <= 1'b1;
    end
  end

  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  p_empty_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (host_rdata == 16'h0000 && !tx_int));
  p_done_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> host_rdata[7] && !host_rdata[5] && !host_rdata[0]);
  p_partial_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_be != 2'b11 && !push && !ctl_reset) |=> $stable(host_rdata) && $stable(tx_int));
  p_int_needs_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    icnt <= cnt);
  p_pop_push_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && push && !ctl_reset) |=> cnt == $past(cnt));
  p_full_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == FULL) |-> !tx_enabled);
  p_error_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push && (ev_xcoll || ev_reclaim) && !ctl_reset) |=> !tx_enabled);
  p_underrun_locks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ur_lock && !ctl_reset) |=> !tx_enabled);
  p_reject_stalled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_enabled && !pop && !ctl_reset) |=> $stable(cnt) && $stable(host_rdata));
endmodule

// File: tb/tx_cmpl_statq_tb.sv
`timescale 1ns/1ps
module tx_cmpl_statq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 0, ev_intreq = 0, ev_underrun = 0, ev_xcoll = 0, ev_stsovf = 0, ev_reclaim = 0;
  logic [7:0] ev_id = '0;
  logic host_wr = 0, tx_restart = 0, ctl_reset = 0;
  logic [1:0] host_be = '0;
  logic [15:0] host_rdata;
  logic tx_enabled, tx_int;

  int vectors = 0;
  int fails = 0;
  logic [12:0] mq[$];
  bit m_en = 1;
  bit m_ur = 0;

  always #4 clk = ~clk;

  tx_cmpl_statq dut_i (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_id(ev_id),
    .ev_intreq(ev_intreq), .ev_underrun(ev_underrun), .ev_xcoll(ev_xcoll),
    .ev_stsovf(ev_stsovf), .ev_reclaim(ev_reclaim), .host_wr(host_wr),
    .host_be(host_be), .host_rdata(host_rdata), .tx_restart(tx_restart),
    .ctl_reset(ctl_reset), .tx_enabled(tx_enabled), .tx_int(tx_int));

  function automatic logic [15:0] exp_rd();
    logic [12:0] h;
    if (mq.size() == 0) return 16'h0000;
    h = mq[0];
    return {h[12:5], 1'b1, h[4], 1'b0, h[3:0], 1'b0};
  endfunction

  function automatic bit exp_int();
    foreach (mq[i]) if (mq[i][4]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(string tag);
    logic [15:0] er;
    er = exp_rd();
    vectors++;
    if (host_rdata !== er || tx_int !== exp_int() || tx_enabled !== m_en) begin
      fails++;
      $display("FAIL %s: rdata=%h int=%b en=%b expected rdata=%h int=%b en=%b",
               tag, host_rdata, tx_int, tx_enabled, er, exp_int(), m_en);
    end
  endtask

  // fl = {intreq, underrun, xcoll, stsovf, reclaim}
  task automatic step(bit v, logic [7:0] id, logic [4:0] fl, bit wr, logic [1:0] be,
                      bit rs, bit cr, string tag);
    bit acc, pp, stl;
    int sz;
    ev_valid = v; ev_id = id;
    {ev_intreq, ev_underrun, ev_xcoll, ev_stsovf, ev_reclaim} = fl;
    host_wr = wr; host_be = be; tx_restart = rs; ctl_reset = cr;
    @(posedge clk);
    sz  = mq.size();
    acc = v && m_en;
    pp  = wr && be == 2'b11 && sz > 0;
    if (cr) begin
      mq.delete(); m_en = 1; m_ur = 0;
    end else begin
      if (pp) void'(mq.pop_front());
      if (acc) mq.push_back({id, fl});
      stl = acc && (fl[3] || fl[2] || fl[0] || mq.size() == 31);
      if (acc && fl[3]) m_ur = 1;
      if (stl) m_en = 0;
      else if (rs && !m_ur && sz < 31) m_en = 1;
    end
    @(negedge clk);
    ev_valid = 0; host_wr = 0; tx_restart = 0; ctl_reset = 0;
    check(tag);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check("R12 reset state");
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 after reset release");
    step(0, 0, 0, 1, 2'b11, 0, 0, "R3 pop on empty");
    step(1, 8'h11, 5'b10000, 0, 0, 0, 0, "R2 R5 entry with intreq");
    step(0, 0, 0, 1, 2'b01, 0, 0, "R4 low lane only");
    step(0, 0, 0, 1, 2'b10, 0, 0, "R4 high lane only");
    step(0, 0, 0, 1, 2'b11, 0, 0, "R4 R5 full pop");
    step(1, 8'h21, 5'b00000, 0, 0, 0, 0, "R1 first no intreq");
    step(1, 8'h22, 5'b10000, 0, 0, 0, 0, "R5 second intreq");
    step(0, 0, 0, 1, 2'b11, 0, 0, "R5 int kept");
    step(1, 8'h23, 5'b00000, 1, 2'b11, 0, 0, "R6 pop and event");
    step(0, 0, 0, 1, 2'b11, 0, 0, "R6 pop");
    step(1, 8'h24, 5'b00000, 1, 2'b11, 0, 0, "R6 empty pop and event");
    step(0, 0, 0, 1, 2'b11, 0, 0, "R3 drain");
    for (int i = 0; i < 31; i++) step(1, 8'(8'h40 + i), 5'(i % 2 ? 5'b10000 : 5'b0), 0, 0, 0, 0, "R1 R7 fill");
    step(1, 8'hEE, 5'b10000, 0, 0, 0, 0, "R10 rejected while full");
    step(0, 0, 0, 0, 0, 1, 0, "R7 restart ignored full");
    step(0, 0, 0, 1, 2'b11, 0, 0, "R7 pop from full");
    step(0, 0, 0, 0, 0, 1, 0, "R7 restart after pop");
    for (int i = 0; i < 31; i++) step(0, 0, 0, 1, 2'b11, 0, 0, "R1 drain order");
    step(1, 8'h51, 5'b00100, 0, 0, 0, 0, "R8 xcoll halts");
    step(1, 8'h52, 5'b00000, 0, 0, 0, 0, "R10 reject halted");
    step(0, 0, 0, 0, 0, 1, 0, "R8 restart");
    step(1, 8'h53, 5'b00001, 0, 0, 0, 0, "R8 reclaim halts");
    step(0, 0, 0, 0, 0, 1, 0, "R8 restart reclaim");
    step(1, 8'h54, 5'b00010, 0, 0, 0, 0, "R11 stsovf no halt");
    step(1, 8'h55, 5'b11000, 0, 0, 0, 0, "R9 underrun halts");
    step(0, 0, 0, 0, 0, 1, 0, "R9 restart ignored");
    step(0, 0, 0, 1, 2'b11, 1, 0, "R9 pop and restart ignored");
    step(0, 0, 0, 0, 0, 0, 1, "R9 controller reset");
    for (int i = 0; i < 4000; i++) begin
      bit v, wr, rs, cr;
      logic [4:0] fl;
      v  = ($urandom % 100) < 55;
      wr = ($urandom % 100) < 45;
      rs = ($urandom % 100) < 15;
      cr = ($urandom % 1000) < 3;
      fl = {($urandom % 2 == 0), ($urandom % 100) < 2, ($urandom % 100) < 3,
            ($urandom % 100) < 5, ($urandom % 100) < 3};
      step(v, 8'($urandom), fl, wr, 2'($urandom | ($urandom % 4 != 0 ? 3 : 0)), rs, cr,
           "R1 R6 R10 random");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule